// File: doc/BRIEF.md
# I/O Controller Transfer Datapath

This block is the controller-side half of the data exchange with a processor and its memory system. On the input side, the processor presents an eight-bit I/O address whose upper four bits name a task and whose lower four bits pick one of sixteen controller registers. It also raises an input-valid strobe. When the task field equals the controller's own task number, the block drives the selected register, with an odd parity bit, in the cycle after the strobe.

On the output side, the address travels through a pipeline. An advance strobe copies the address lines into a second stage. A transport-start strobe then moves that copy into a third stage. Only the third stage is compared with the task number. Because of this, a new address can be loaded while data for the previous one is still on its way. When output-valid arrives and the third stage matches, the block latches the data together with the memory's double-error flag. One cycle later it checks the odd parity bit that follows the data.

A write to register 0 acts as the control register. A value of zero quiesces the controller, and a nonzero value sets the wakeup enable from bit 0. Dropping the run input has the same quiescing effect. In both cases wakeup requests stay blocked until software enables them again.

Top module: `ioctl_xfer_top`

## Requirements
- R1: When `in_valid` is high and `addr[7:4]` equals `ctl_task`, `rd_oe` is high in the next cycle and `rd_data` and `rd_par` are valid together in that cycle. `rd_par` makes the 17 bits hold an odd number of ones. With no match, `rd_oe` stays low.
- R2: The readable registers are selected by `addr[3:0]`. Register 0 returns the `DEV_ID` parameter (default 16'hB7C3). Register 1 returns status: bit 0 is the wakeup enable, bit 1 is the sticky parity error, bit 2 is the last fault flag, and the other bits are zero. Register 2 returns the last accepted output data. Every other register returns zero.
- R3: `adv_pipe` copies `addr` into the second address stage. After that, `addr` may change without affecting the transfer.
- R4: The third stage is loaded from the second stage only on `xport_start`. When `adv_pipe` and `xport_start` arrive in the same cycle, the old second-stage address moves on while the new address enters the second stage.
- R5: Output data is accepted only in a cycle where `out_valid` is high and the third-stage task equals `ctl_task`. In the next cycle `wr_strobe` is high for one cycle, with `wr_data` and `wr_reg` (the third-stage register field).
- R6: `out_fault`, sampled in the cycle of `out_valid`, is stored with the data and shown on `wr_fault`.
- R7: `out_par` is sampled one cycle after an accepted `out_valid`. If `par_chk_en` is high and the data plus parity hold an even number of ones, `par_err` is set. It stays set until a soft reset, run loss or `rst_n`. With `par_chk_en` low, bad parity has no effect.
- R8: An accepted write of zero to register 0 clears the wakeup enable and `par_err`. An accepted nonzero write to register 0 sets the wakeup enable to bit 0 of the data.
- R9: While `run` is low, the wakeup enable, `par_err`, the fault flag, both address-stage valids, `rd_oe` and `wr_strobe` are cleared. After `run` returns, the enable stays low until a control write sets it.
- R10: `wake_req` is high only when `dev_wake` and the wakeup enable are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | System run level; low quiesces the controller |
| ctl_task | input | 4 | Task number assigned to this controller |
| addr | input | 8 | I/O address: task in [7:4], register in [3:0] |
| in_valid | input | 1 | Input-valid strobe |
| adv_pipe | input | 1 | Advance strobe: capture address into stage 2 |
| xport_start | input | 1 | Transport-start strobe: move stage 2 into stage 3 |
| out_valid | input | 1 | Output data valid |
| out_data | input | 16 | Output data from memory |
| out_fault | input | 1 | Double-error flag, sampled with out_valid |
| out_par | input | 1 | Odd parity bit, one cycle after the data |
| par_chk_en | input | 1 | Enable parity checking on output data |
| dev_wake | input | 1 | Device needs service |
| rd_data | output | 16 | Read data |
| rd_par | output | 1 | Odd parity of rd_data |
| rd_oe | output | 1 | Read data is being driven |
| wr_data | output | 16 | Last accepted output data |
| wr_reg | output | 4 | Register field of the last accepted write |
| wr_fault | output | 1 | Fault flag stored with wr_data |
| wr_strobe | output | 1 | One-cycle pulse after an accepted write |
| par_err | output | 1 | Sticky output parity error |
| wake_en | output | 1 | Wakeup enable |
| wake_req | output | 1 | Gated wakeup request |

## Verification
The hardest corner case is a transport start that coincides with an advance strobe. A design that fed the third stage from the address lines would label the first data with the second address, so the bench checks `wr_reg` for both writes of an overlapped pair. The bench also changes the address lines right after the advance strobe and sends output to another task's address. A design that compared live lines or the second stage would accept foreign data, and these tests expose that. Parity is checked with deliberately bad bits, both with checking enabled and disabled. A design that sampled parity in the data cycle, or ignored the enable, would set or miss the sticky flag. Finally, the bench confirms that wakeups stay blocked after both a control write of zero and a run drop; a design that restored the old enable would raise `wake_req` early.

// File: rtl/ioctl_pkg.sv
package ioctl_pkg;
  localparam int TASK_W = 4;
  localparam int REG_W  = 4;
  localparam int DATA_W = 16;
  localparam int ADDR_W = TASK_W + REG_W;
  localparam int NREGS  = 1 << REG_W;

  typedef struct packed {
    logic [TASK_W-1:0] task_no;
    logic [REG_W-1:0]  reg_no;
  } io_addr_t;

  // register numbers with a fixed meaning
  localparam logic [REG_W-1:0] REG_ID_CTL = '0;
  localparam logic [REG_W-1:0] REG_STATUS = REG_W'(1);
  localparam logic [REG_W-1:0] REG_LAST   = REG_W'(2);

  // parity bit that makes data plus bit hold an odd count of ones
  function automatic logic odd_par(input logic [DATA_W-1:0] d);
    return ~(^d);
  endfunction

  // true when data plus parity hold an odd count of ones
  function automatic logic par_good(input logic [DATA_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction
endpackage

// File: rtl/ioctl_in_path.sv
module ioctl_in_path
  import ioctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] DEV_ID = 16'hB7C3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [TASK_W-1:0]     ctl_task,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  in_valid,
  input  logic [DATA_W-1:0]     status_word,
  input  logic [DATA_W-1:0]     last_data,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_par,
  output logic                  rd_oe
);
  io_addr_t          sel;
  logic              rd_hit;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    sel    = io_addr_t'(addr);
    rd_hit = in_valid && (sel.task_no == ctl_task);
    case (sel.reg_no)
      REG_ID_CTL: rd_mux = DEV_ID;
      REG_STATUS: rd_mux = status_word;
      REG_LAST:   rd_mux = last_data;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_oe   <= 1'b0;
      rd_data <= '0;
      rd_par  <= 1'b1;
    end else if (!run) begin
      rd_oe   <= 1'b0;
    end else begin
      rd_oe <= rd_hit;
      if (rd_hit) begin
        rd_data <= rd_mux;
        rd_par  <= odd_par(rd_mux);
      end
    end
  end

  // R1: read data only in the cycle after a matching input strobe
  assert_rd_after_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> $past(in_valid && run && (addr[ADDR_W-1:REG_W] == ctl_task)));

  // R1: data and parity leave together with odd weight
  assert_rd_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> par_good(rd_data, rd_par));
endmodule

// File: rtl/ioctl_out_pipe.sv
module ioctl_out_pipe
  import ioctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TASK_W-1:0] ctl_task,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_pipe,
  input  logic              xport_start,
  output logic [REG_W-1:0]  s3_reg,
  output logic              s3_hit
);
  io_addr_t s2_addr, s3_addr;
  logic     s2_valid, s3_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_addr  <= '0;
      s3_addr  <= '0;
      s2_valid <= 1'b0;
      s3_valid <= 1'b0;
    end else if (!run) begin
      s2_valid <= 1'b0;
      s3_valid <= 1'b0;
    end else begin
      if (adv_pipe) begin
        s2_addr  <= io_addr_t'(addr);
        s2_valid <= 1'b1;
      end
      if (xport_start) begin
        s3_addr  <= s2_addr;
        s3_valid <= s2_valid;
      end
    end
  end

  always_comb begin
    s3_reg = s3_addr.reg_no;
    s3_hit = s3_valid && (s3_addr.task_no == ctl_task);
  end

  // R3: second stage holds what the lines carried at the advance strobe
  assert_s2_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv_pipe && run) |-> (s2_addr == $past(addr)));

  // R4: third stage takes the previous second-stage value on transport start
  assert_s3_from_s2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xport_start && run) |-> (s3_addr == $past(s2_addr)));

  // R4: third stage holds without a transport start
  assert_s3_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!xport_start && run) |-> ($stable(s3_addr) && $stable(s3_valid)));
endmodule

// File: rtl/ioctl_wr_capture.sv
module ioctl_wr_capture
  import ioctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              s3_hit,
  input  logic [REG_W-1:0]  s3_reg,
  input  logic              out_valid,
  input  logic [DATA_W-1:0] out_data,
  input  logic              out_fault,
  input  logic              out_par,
  input  logic              par_chk_en,
  input  logic              dev_wake,
  output logic [DATA_W-1:0] wr_data,
  output logic [REG_W-1:0]  wr_reg,
  output logic              wr_fault,
  output logic              wr_strobe,
  output logic              par_err,
  output logic              wake_en,
  output logic              wake_req
);
  logic accept, ctl_wr, soft_rst, par_pend, par_bad;

  always_comb begin
    accept   = out_valid && s3_hit;
    ctl_wr   = accept && (s3_reg == REG_ID_CTL);
    soft_rst = ctl_wr && (out_data == '0);
    par_bad  = par_pend && par_chk_en && !par_good(wr_data, out_par);
    wake_req = dev_wake && wake_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_data   <= '0;
      wr_reg    <= '0;
      wr_fault  <= 1'b0;
      wr_strobe <= 1'b0;
      par_pend  <= 1'b0;
      par_err   <= 1'b0;
      wake_en   <= 1'b0;
    end else if (!run) begin
      wr_fault  <= 1'b0;
      wr_strobe <= 1'b0;
      par_pend  <= 1'b0;
      par_err   <= 1'b0;
      wake_en   <= 1'b0;
    end else begin
      wr_strobe <= accept;
      par_pend  <= accept;
      if (accept) begin
        wr_data  <= out_data;
        wr_reg   <= s3_reg;
        wr_fault <= out_fault;
      end
      if (soft_rst) begin
        wake_en <= 1'b0;
        par_err <= 1'b0;
      end else begin
        if (ctl_wr)  wake_en <= out_data[0];
        if (par_bad) par_err <= 1'b1;
      end
    end
  end

  // R5: a write pulse needs a matching third stage and output-valid
  assert_strobe_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(out_valid && s3_hit && run));

  // R6: fault flag travels with its data
  assert_fault_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (wr_fault == $past(out_fault)));

  // R7: parity error only rises after a checked pending write
  assert_par_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> $past(par_pend && par_chk_en));

  // R8: soft reset leaves wakeups disabled
  assert_soft_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst && run) |-> (!wake_en && !par_err));

  // R9: run loss clears enable and error
  assert_run_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> (!wake_en && !par_err && !wr_strobe));

  // R10: no wakeup request without enable
  assert_wake_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> wake_en);
endmodule

// File: rtl/ioctl_xfer_top.sv
module ioctl_xfer_top
  import ioctl_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'hB7C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [3:0]  ctl_task,
  input  logic [7:0]  addr,
  input  logic        in_valid,
  input  logic        adv_pipe,
  input  logic        xport_start,
  input  logic        out_valid,
  input  logic [15:0] out_data,
  input  logic        out_fault,
  input  logic        out_par,
  input  logic        par_chk_en,
  input  logic        dev_wake,
  output logic [15:0] rd_data,
  output logic        rd_par,
  output logic        rd_oe,
  output logic [15:0] wr_data,
  output logic [3:0]  wr_reg,
  output logic        wr_fault,
  output logic        wr_strobe,
  output logic        par_err,
  output logic        wake_en,
  output logic        wake_req
);
  logic [REG_W-1:0]  s3_reg;
  logic              s3_hit;
  logic [DATA_W-1:0] status_word;

  always_comb begin
    status_word    = '0;
    status_word[0] = wake_en;
    status_word[1] = par_err;
    status_word[2] = wr_fault;
  end

  ioctl_in_path #(.DEV_ID(DEV_ID)) u_in (
    .clk(clk), .rst_n(rst_n), .run(run), .ctl_task(ctl_task), .addr(addr),
    .in_valid(in_valid), .status_word(status_word), .last_data(wr_data),
    .rd_data(rd_data), .rd_par(rd_par), .rd_oe(rd_oe)
  );

  ioctl_out_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .run(run), .ctl_task(ctl_task), .addr(addr),
    .adv_pipe(adv_pipe), .xport_start(xport_start),
    .s3_reg(s3_reg), .s3_hit(s3_hit)
  );

  ioctl_wr_capture u_wr (
    .clk(clk), .rst_n(rst_n), .run(run), .s3_hit(s3_hit), .s3_reg(s3_reg),
    .out_valid(out_valid), .out_data(out_data), .out_fault(out_fault),
    .out_par(out_par), .par_chk_en(par_chk_en), .dev_wake(dev_wake),
    .wr_data(wr_data), .wr_reg(wr_reg), .wr_fault(wr_fault),
    .wr_strobe(wr_strobe), .par_err(par_err), .wake_en(wake_en),
    .wake_req(wake_req)
  );
endmodule

// File: tb/sim_ioctl_xfer_top.sv
`timescale 1ns/1ps
module sim_ioctl_xfer_top;
  localparam logic [15:0] ID = 16'hB7C3;
  localparam logic [3:0]  MY = 4'd9;

  logic clk = 0, rst_n = 0, run = 1;
  logic [3:0] ctl_task = MY;
  logic [7:0] addr = '0;
  logic in_valid = 0, adv_pipe = 0, xport_start = 0, out_valid = 0;
  logic [15:0] out_data = '0;
  logic out_fault = 0, out_par = 0, par_chk_en = 0, dev_wake = 0;
  logic [15:0] rd_data, wr_data;
  logic rd_par, rd_oe, wr_fault, wr_strobe, par_err, wake_en, wake_req;
  logic [3:0] wr_reg;

  int n_chk = 0, n_fail = 0;
  logic g_oe, g_par, g_stb, g_flt;
  logic [15:0] g_data;
  logic [3:0] g_reg;

  always #2.5 clk = ~clk;

  ioctl_xfer_top #(.DEV_ID(ID)) u0 (.*);

  function automatic logic bpar(input logic [15:0] d);
    int ones = 0;
    for (int i = 0; i < 16; i++) if (d[i]) ones++;
    return (ones % 2 == 0);
  endfunction

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [3:0] t, input logic [3:0] r);
    addr = {t, r}; in_valid = 1; tick;
    g_oe = rd_oe; g_data = rd_data; g_par = rd_par;
    in_valid = 0; addr = 8'h00;
  endtask

  task automatic do_write(input logic [3:0] t, input logic [3:0] r, input logic [15:0] d,
                          input logic flt, input logic good);
    addr = {t, r}; adv_pipe = 1; tick;
    adv_pipe = 0; addr = 8'hFF; xport_start = 1; tick;      // R3: lines change after advance
    xport_start = 0; addr = 8'h00; out_valid = 1; out_data = d; out_fault = flt; tick;
    g_stb = wr_strobe; g_data = wr_data; g_reg = wr_reg; g_flt = wr_fault;
    out_valid = 0; out_fault = 0; out_data = 16'hDEAD; out_par = good ? bpar(d) : ~bpar(d); tick;
    out_par = 0;
  endtask

  task automatic t_reset;
    dev_wake = 1;
    chk("R9 reset rd_oe", 16'(rd_oe), 16'd0);
    chk("R9 reset wake_en", 16'(wake_en), 16'd0);
    chk("R7 reset par_err", 16'(par_err), 16'd0);
    chk("R10 reset wake_req", 16'(wake_req), 16'd0);
    dev_wake = 0;
  endtask

  task automatic t_read;
    do_read(MY, 4'd0);
    chk("R1 rd_oe match", 16'(g_oe), 16'd1);
    chk("R2 id value", g_data, ID);
    chk("R1 parity", 16'(g_par), 16'(bpar(ID)));
    tick;
    chk("R1 rd_oe drops", 16'(rd_oe), 16'd0);
    do_read(MY, 4'd5);
    chk("R2 unused reg", g_data, 16'd0);
    chk("R1 parity zero", 16'(g_par), 16'd1);
    do_read(4'd3, 4'd0);
    chk("R1 other task", 16'(g_oe), 16'd0);
  endtask

  task automatic t_enable;
    do_write(MY, 4'd0, 16'h0001, 0, 1);
    chk("R8 enable set", 16'(wake_en), 16'd1);
    dev_wake = 1; #1;
    chk("R10 wake_req", 16'(wake_req), 16'd1);
    dev_wake = 0;
    do_read(MY, 4'd1);
    chk("R2 status enable", g_data, 16'h0001);
  endtask

  task automatic t_data;
    do_write(MY, 4'd3, 16'h5A5A, 0, 1);
    chk("R5 strobe", 16'(g_stb), 16'd1);
    chk("R5 data", g_data, 16'h5A5A);
    chk("R5 reg", 16'(g_reg), 16'd3);
    chk("R5 strobe one cycle", 16'(wr_strobe), 16'd0);
    do_read(MY, 4'd2);
    chk("R2 last data", g_data, 16'h5A5A);
    do_write(4'd4, 4'd3, 16'h1234, 0, 1);
    chk("R5 mismatch no strobe", 16'(g_stb), 16'd0);
    do_read(MY, 4'd2);
    chk("R5 mismatch data kept", g_data, 16'h5A5A);
  endtask

  task automatic t_fault;
    do_write(MY, 4'd4, 16'h0F0F, 1, 1);
    chk("R6 fault flag", 16'(g_flt), 16'd1);
    do_read(MY, 4'd1);
    chk("R6 status fault", g_data, 16'h0005);
    do_write(MY, 4'd4, 16'h0F0E, 0, 1);
    chk("R6 fault cleared by clean data", 16'(g_flt), 16'd0);
  endtask

  task automatic t_overlap;
    par_chk_en = 1;
    addr = {MY, 4'd6}; adv_pipe = 1; tick;
    addr = {MY, 4'd7}; xport_start = 1; tick;             // R4 same-cycle advance and transport
    adv_pipe = 0; xport_start = 0; addr = 8'h00;
    out_valid = 1; out_data = 16'h1111; tick;
    chk("R4 first write reg", 16'(wr_reg), 16'd6);
    out_valid = 0; out_par = bpar(16'h1111); xport_start = 1; tick;
    xport_start = 0; out_par = 0; out_valid = 1; out_data = 16'h2222; tick;
    chk("R4 second write reg", 16'(wr_reg), 16'd7);
    chk("R4 second write data", wr_data, 16'h2222);
    out_valid = 0; out_par = bpar(16'h2222); tick;
    out_par = 0;
    chk("R7 good parity no error", 16'(par_err), 16'd0);
  endtask

  task automatic t_parity;
    par_chk_en = 0;
    do_write(MY, 4'd5, 16'h00FF, 0, 0);
    chk("R7 check disabled", 16'(par_err), 16'd0);
    par_chk_en = 1;
    do_write(MY, 4'd5, 16'h00FF, 0, 0);
    chk("R7 bad parity", 16'(par_err), 16'd1);
    do_write(MY, 4'd5, 16'h0001, 0, 1);
    chk("R7 sticky", 16'(par_err), 16'd1);
  endtask

  task automatic t_soft;
    do_write(MY, 4'd0, 16'h0000, 0, 1);
    chk("R8 soft clears enable", 16'(wake_en), 16'd0);
    chk("R8 soft clears par_err", 16'(par_err), 16'd0);
    dev_wake = 1; #1;
    chk("R10 blocked after soft reset", 16'(wake_req), 16'd0);
    dev_wake = 0;
    do_write(MY, 4'd0, 16'h0002, 0, 1);
    chk("R8 nonzero bit0 clear", 16'(wake_en), 16'd0);
  endtask

  task automatic t_run;
    do_write(MY, 4'd0, 16'h0001, 0, 1);
    addr = {MY, 4'd3}; adv_pipe = 1; tick;
    adv_pipe = 0; xport_start = 1; tick;
    xport_start = 0; run = 0; tick;
    run = 1; tick;
    chk("R9 enable cleared", 16'(wake_en), 16'd0);
    out_valid = 1; out_data = 16'h7777; tick;
    out_valid = 0;
    chk("R9 pipeline flushed", 16'(wr_strobe), 16'd0);
    tick;
    do_read(MY, 4'd1);
    chk("R9 status zero", g_data, 16'h0000);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1; tick;
    t_reset; t_read; t_enable; t_data; t_fault;
    t_overlap; t_parity; t_soft; t_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule